// File: doc/BRIEF.md
# Peripheral Access Wait-State Generator

This block sits between a CPU bus and a group of slow peripheral registers. It decodes each access by address and direction. For a register that needs time to respond, it holds the CPU by asserting a wait signal for a set number of CPU clocks. Two kinds of register have a fixed stall: the watchdog control register, on a write, and the two serial receive buffers, on a read. The analog-to-digital converter registers use a stall that is worked out at run time from the ratio between the converter clock and the CPU clock. These are four control registers, stalled on a write, and the conversion result, stalled on a read.

The CPU clock is the main oscillator divided by 2^k, where k is set by `cpu_div`. The converter clock is the main oscillator divided by 2 when `adc_fast` is 1, and by 4 when it is 0. The converter stall is the ratio term 2·fCPU/fADC plus one. Any fraction of the ratio term is rounded up when it is at least half a CPU period, and dropped otherwise. A computed count of one inserts no stall at all.

When the CPU runs from the subsystem clock (`sub_clk` = 1), the slow registers cannot complete a handshake. In that case the block raises `illegal_o` and does not stall, so the CPU does not hang.

The controller has three states:
- IDLE: wait for an access.
- STALL: count down the remaining wait cycles.
- DONE: one completion cycle with wait low.

It has four transitions:
- IDLE→STALL: a stall of two or more cycles begins.
- IDLE→DONE: a one-cycle stall.
- STALL→DONE: the counter reaches its last cycle.
- DONE→IDLE: always, one cycle later.

Top module: `periph_wait_gen`

## Requirements
- R1: While `rst_n` is low, `wait_o` and `illegal_o` are both low, whatever the strobes are doing.
- R2: A write to the watchdog control address (default 0x10) holds `wait_o` high for exactly 3 cycles. The first of these is the cycle the strobe appears, with `wait_o` driven combinationally. This count does not depend on `cpu_div` or `adc_fast`.
- R3: A read of either receive buffer address (defaults 0x20 and 0x28) holds `wait_o` high for exactly 1 cycle.
- R4: Converter stalls work as follows:
  - A write to a converter control address (defaults 0x40, 0x41, 0x42, 0x43) or a read of the result address (default 0x44) stalls for N cycles.
  - The ratio term is 2^(1+m−k), where m=1 when `adc_fast`=1 and m=2 when `adc_fast`=0.
  - The fraction of the ratio term rounds up when it is ≥ 0.5 and is dropped otherwise.
  - N is the rounded ratio term plus one.
  - Resulting N: for `adc_fast`=1, N is 5,3,2,2,1 for k=0..4; for `adc_fast`=0, N is 9,5,3,2,2.
- R5: When the computed converter count N equals 1, `wait_o` stays low and the access completes in its first cycle.
- R6: A `cpu_div` value above 4 is treated as 4.
- R7: An access to any other address gives no wait and no flag. So does an access to a listed register in the direction that does not stall (a read of watchdog or control, a write of receive buffer or result).
- R8: With `sub_clk`=1, a stall-generating access to a listed register drives `illegal_o` high in that cycle and leaves `wait_o` low. This also applies to a converter access whose N is 1.
- R9: After the last wait cycle there is one completion cycle with `wait_o` low, even if the strobe is still held. A strobe held past that cycle is taken as a new access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Register address of the current access |
| rd | input | 1 | Read strobe, held until a cycle with wait low |
| wr | input | 1 | Write strobe, held until a cycle with wait low |
| cpu_div | input | DIV_W | CPU clock divider exponent k |
| adc_fast | input | 1 | Converter speed select: 1 = fX/2, 0 = fX/4 |
| sub_clk | input | 1 | CPU running from subsystem clock, main clock stopped |
| wait_o | output | 1 | Stall request to the CPU |
| illegal_o | output | 1 | Stall-generating access attempted on the subsystem clock |

## Verification
The bench sweeps every listed and unlisted address, both directions, both speed settings, all eight divider codes and both clock sources. It counts the stall length of every access against a real-valued model of the ratio formula.

It targets the following corner cases:
- **Rounding boundary at k=3 with the fast converter (ratio 0.5).** A design that truncates there would stall 1 cycle instead of 2.
- **k=4 with the fast converter (N=1).** A design that forgot the no-wait rule would stall one cycle.
- **Divider codes 5 to 7.** Without the clamp, these would shift the ratio to zero and change the count.
- **Wrong-direction accesses and subsystem-clock accesses.** These expose a decoder that ignores direction or a design that stalls instead of flagging.
- **Back-to-back held strobe.** This shows whether the completion cycle is skipped, which would make the stall run on without a gap.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_DONE  = 2'd2
    } wsg_state_t;

    // Class of a decoded access, only for the stall-generating direction
    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_WDOG = 2'd1,
        KIND_RX   = 2'd2,
        KIND_ADC  = 2'd3
    } wait_kind_t;

endpackage

// File: rtl/wsg_decode.sv
module wsg_decode
    import wsg_pkg::*;
#(
    parameter int                ADDR_W        = 8,
    parameter logic [ADDR_W-1:0] WDOG_ADDR     = 8'h10,
    parameter logic [ADDR_W-1:0] RXA_ADDR      = 8'h20,
    parameter logic [ADDR_W-1:0] RXB_ADDR      = 8'h28,
    parameter logic [ADDR_W-1:0] ADC_MODE_ADDR = 8'h40,
    parameter logic [ADDR_W-1:0] ADC_CHAN_ADDR = 8'h41,
    parameter logic [ADDR_W-1:0] PF_MODE_ADDR  = 8'h42,
    parameter logic [ADDR_W-1:0] PF_LEVEL_ADDR = 8'h43,
    parameter logic [ADDR_W-1:0] ADC_RES_ADDR  = 8'h44
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output wait_kind_t        kind
);

    localparam int N_CTRL = 4;
    localparam int N_RX   = 2;
    localparam logic [ADDR_W-1:0] CTRL_ADDRS [N_CTRL] =
        '{ADC_MODE_ADDR, ADC_CHAN_ADDR, PF_MODE_ADDR, PF_LEVEL_ADDR};
    localparam logic [ADDR_W-1:0] RX_ADDRS [N_RX] = '{RXA_ADDR, RXB_ADDR};

    logic [N_CTRL-1:0] ctrl_hit;
    logic [N_RX-1:0]   rx_hit;
    logic              wdog_hit;
    logic              res_hit;

    // One comparator per converter control register
    for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
        assign ctrl_hit[g] = (addr == CTRL_ADDRS[g]);
    end

    // One comparator per receive buffer
    for (genvar g = 0; g < N_RX; g++) begin : g_rx
        assign rx_hit[g] = (addr == RX_ADDRS[g]);
    end

    assign wdog_hit = (addr == WDOG_ADDR);
    assign res_hit  = (addr == ADC_RES_ADDR);

    // Direction qualifies each class: only the stalling direction decodes
    always_comb begin
        kind = KIND_NONE;
        if (wr && wdog_hit) begin
            kind = KIND_WDOG;
        end else if (rd && (|rx_hit)) begin
            kind = KIND_RX;
        end else if ((wr && (|ctrl_hit)) || (rd && res_hit)) begin
            kind = KIND_ADC;
        end
    end

endmodule

// File: rtl/wsg_ratio.sv
module wsg_ratio #(
    parameter int DIV_W   = 3,
    parameter int MAX_DIV = 4,
    parameter int WAIT_W  = 4
) (
    input  logic [DIV_W-1:0]  cpu_div,
    input  logic              adc_fast,
    output logic [WAIT_W-1:0] adc_wait
);

    // Fixed-point term: enough fraction bits that no shift loses a bit
    localparam int FRAC_W = MAX_DIV;
    localparam int INT_W  = 4;              // ratio term up to 2^3
    localparam int TERM_W = FRAC_W + INT_W;
    localparam logic [TERM_W-1:0] SCALE_FAST = TERM_W'(1) << (FRAC_W + 2);
    localparam logic [TERM_W-1:0] SCALE_SLOW = TERM_W'(1) << (FRAC_W + 3);
    localparam logic [DIV_W-1:0]  DIV_CAP    = DIV_W'(MAX_DIV);

    logic [DIV_W-1:0]  k_eff;
    logic [TERM_W-1:0] term;
    logic [INT_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac_part;
    logic              round_up;
    logic [WAIT_W-1:0] n_calc;

    // Out-of-range divider codes behave as the slowest supported CPU clock
    assign k_eff = (cpu_div > DIV_CAP) ? DIV_CAP : cpu_div;

    // 2*fCPU/fADC = 2^(1+m) / 2^k, computed by shifting a scaled one
    assign term      = (adc_fast ? SCALE_FAST : SCALE_SLOW) >> k_eff;
    assign int_part  = term[TERM_W-1:FRAC_W];
    assign frac_part = term[FRAC_W-1:0];

    // Remainder of at least half a CPU period rounds up
    assign round_up  = frac_part[FRAC_W-1];

    assign n_calc = WAIT_W'(int_part) + WAIT_W'(round_up) + WAIT_W'(1);

    // A count of one inserts no stall
    assign adc_wait = (n_calc == WAIT_W'(1)) ? '0 : n_calc;

endmodule

// File: rtl/wsg_fsm.sv
module wsg_fsm
    import wsg_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] len,
    output logic              stall,
    output wsg_state_t        state
);

    wsg_state_t        state_d;
    logic [WAIT_W-1:0] cnt_q;
    logic [WAIT_W-1:0] cnt_d;
    logic              go;

    assign go = start && (len != '0);

    // Next-state and counter
    always_comb begin
        state_d = state;
        cnt_d   = cnt_q;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    cnt_d   = len - WAIT_W'(1);
                    state_d = (len == WAIT_W'(1)) ? ST_DONE : ST_STALL;
                end
            end
            ST_STALL: begin
                if (cnt_q == WAIT_W'(1)) begin
                    state_d = ST_DONE;
                end
                cnt_d = cnt_q - WAIT_W'(1);
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs: first wait cycle is combinational from the access
    always_comb begin
        stall = 1'b0;
        unique case (state)
            ST_IDLE:  stall = rst_n && go;
            ST_STALL: stall = rst_n;
            ST_DONE:  stall = 1'b0;
            default:  stall = 1'b0;
        endcase
    end

endmodule

// File: rtl/periph_wait_gen.sv
module periph_wait_gen
    import wsg_pkg::*;
#(
    parameter int                ADDR_W        = 8,
    parameter int                DIV_W         = 3,
    parameter int                MAX_DIV       = 4,
    parameter int                WAIT_W        = 4,
    parameter int                WDOG_WAIT     = 3,
    parameter int                RX_WAIT       = 1,
    parameter logic [ADDR_W-1:0] WDOG_ADDR     = 8'h10,
    parameter logic [ADDR_W-1:0] RXA_ADDR      = 8'h20,
    parameter logic [ADDR_W-1:0] RXB_ADDR      = 8'h28,
    parameter logic [ADDR_W-1:0] ADC_MODE_ADDR = 8'h40,
    parameter logic [ADDR_W-1:0] ADC_CHAN_ADDR = 8'h41,
    parameter logic [ADDR_W-1:0] PF_MODE_ADDR  = 8'h42,
    parameter logic [ADDR_W-1:0] PF_LEVEL_ADDR = 8'h43,
    parameter logic [ADDR_W-1:0] ADC_RES_ADDR  = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DIV_W-1:0]  cpu_div,
    input  logic              adc_fast,
    input  logic              sub_clk,
    output logic              wait_o,
    output logic              illegal_o
);

    localparam logic [WAIT_W-1:0] WDOG_LEN = WAIT_W'(WDOG_WAIT);
    localparam logic [WAIT_W-1:0] RX_LEN   = WAIT_W'(RX_WAIT);

    wait_kind_t        kind;
    logic [WAIT_W-1:0] adc_wait;
    logic [WAIT_W-1:0] len;
    logic              start;
    wsg_state_t        fsm_state;

    wsg_decode #(
        .ADDR_W       (ADDR_W),
        .WDOG_ADDR    (WDOG_ADDR),
        .RXA_ADDR     (RXA_ADDR),
        .RXB_ADDR     (RXB_ADDR),
        .ADC_MODE_ADDR(ADC_MODE_ADDR),
        .ADC_CHAN_ADDR(ADC_CHAN_ADDR),
        .PF_MODE_ADDR (PF_MODE_ADDR),
        .PF_LEVEL_ADDR(PF_LEVEL_ADDR),
        .ADC_RES_ADDR (ADC_RES_ADDR)
    ) u_decode (
        .addr(addr),
        .rd  (rd),
        .wr  (wr),
        .kind(kind)
    );

    wsg_ratio #(
        .DIV_W  (DIV_W),
        .MAX_DIV(MAX_DIV),
        .WAIT_W (WAIT_W)
    ) u_ratio (
        .cpu_div (cpu_div),
        .adc_fast(adc_fast),
        .adc_wait(adc_wait)
    );

    // Stall length per access class
    always_comb begin
        len = '0;
        unique case (kind)
            KIND_WDOG: len = WDOG_LEN;
            KIND_RX:   len = RX_LEN;
            KIND_ADC:  len = adc_wait;
            KIND_NONE: len = '0;
            default:   len = '0;
        endcase
    end

    // On the subsystem clock a slow access is flagged, never stalled
    assign start = (kind != KIND_NONE) && !sub_clk;

    wsg_fsm #(
        .WAIT_W(WAIT_W)
    ) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .len  (len),
        .stall(wait_o),
        .state(fsm_state)
    );

    assign illegal_o = rst_n && (fsm_state == ST_IDLE)
                       && (kind != KIND_NONE) && sub_clk;

endmodule

// File: rtl/periph_wait_gen_checker.sv
module periph_wait_gen_checker
    import wsg_pkg::*;
#(
    parameter int                ADDR_W        = 8,
    parameter logic [ADDR_W-1:0] WDOG_ADDR     = 8'h10,
    parameter logic [ADDR_W-1:0] RXA_ADDR      = 8'h20,
    parameter logic [ADDR_W-1:0] RXB_ADDR      = 8'h28,
    parameter logic [ADDR_W-1:0] ADC_MODE_ADDR = 8'h40,
    parameter logic [ADDR_W-1:0] ADC_CHAN_ADDR = 8'h41,
    parameter logic [ADDR_W-1:0] PF_MODE_ADDR  = 8'h42,
    parameter logic [ADDR_W-1:0] PF_LEVEL_ADDR = 8'h43,
    parameter logic [ADDR_W-1:0] ADC_RES_ADDR  = 8'h44
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd,
    input logic              wr,
    input logic              sub_clk,
    input logic              wait_o,
    input logic              illegal_o,
    input wsg_state_t        fsm_state
);

    logic idle;
    logic listed;
    logic wdog_wr;
    logic rx_rd;

    assign idle    = (fsm_state == ST_IDLE);
    assign wdog_wr = wr && !rd && (addr == WDOG_ADDR);
    assign rx_rd   = rd && !wr && ((addr == RXA_ADDR) || (addr == RXB_ADDR));
    assign listed  = (addr == WDOG_ADDR) || (addr == RXA_ADDR) ||
                     (addr == RXB_ADDR) || (addr == ADC_MODE_ADDR) ||
                     (addr == ADC_CHAN_ADDR) || (addr == PF_MODE_ADDR) ||
                     (addr == PF_LEVEL_ADDR) || (addr == ADC_RES_ADDR);

    // R1: outputs quiet in reset
    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!wait_o && !illegal_o));

    // R2: watchdog write stalls three cycles
    a_r2_watchdog_three: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && wdog_wr && !sub_clk) |-> wait_o ##1 wait_o ##1 wait_o ##1 !wait_o);

    // R3: receive buffer read stalls one cycle
    a_r3_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rx_rd && !sub_clk) |-> wait_o ##1 !wait_o);

    // R4: the stall holds wait for as long as the controller counts
    a_r4_stall_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_STALL) |-> wait_o);

    // R7: unlisted addresses never stall or flag
    a_r7_other_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && (rd || wr) && !listed) |-> (!wait_o && !illegal_o));

    // R8: a flagged access never stalls
    a_r8_flag_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wait_o && sub_clk));

    // R9: completion cycle has wait low, then idle
    a_r9_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_DONE) |-> !wait_o ##1 (fsm_state == ST_IDLE));

endmodule

bind periph_wait_gen periph_wait_gen_checker #(
    .ADDR_W       (ADDR_W),
    .WDOG_ADDR    (WDOG_ADDR),
    .RXA_ADDR     (RXA_ADDR),
    .RXB_ADDR     (RXB_ADDR),
    .ADC_MODE_ADDR(ADC_MODE_ADDR),
    .ADC_CHAN_ADDR(ADC_CHAN_ADDR),
    .PF_MODE_ADDR (PF_MODE_ADDR),
    .PF_LEVEL_ADDR(PF_LEVEL_ADDR),
    .ADC_RES_ADDR (ADC_RES_ADDR)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .rd       (rd),
    .wr       (wr),
    .sub_clk  (sub_clk),
    .wait_o   (wait_o),
    .illegal_o(illegal_o),
    .fsm_state(fsm_state)
);

// File: tb/test_periph_wait_gen.sv
module test_periph_wait_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] cpu_div = 3'd0;
    logic       adc_fast = 1'b0;
    logic       sub_clk = 1'b0;
    logic       wait_o;
    logic       illegal_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    periph_wait_gen i_periph_wait_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .rd       (rd),
        .wr       (wr),
        .cpu_div  (cpu_div),
        .adc_fast (adc_fast),
        .sub_clk  (sub_clk),
        .wait_o   (wait_o),
        .illegal_o(illegal_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (addr=%h rd=%0b wr=%0b k=%0d fast=%0b sub=%0b)",
                     tag, act, exp, addr, rd, wr, cpu_div, adc_fast, sub_clk);
        end
    endtask

    // Real-valued model of the converter stall
    function automatic int ref_adc(input int k, input bit fast);
        int  kk;
        real term;
        int  ip;
        int  n;
        kk   = (k > 4) ? 4 : k;
        term = 2.0 * (fast ? 2.0 : 4.0) / (2.0 ** kk);
        ip   = int'($floor(term));
        n    = ip + (((term - ip) >= 0.5) ? 1 : 0) + 1;
        return (n == 1) ? 0 : n;
    endfunction

    task automatic do_access(input logic [7:0] a, input bit is_wr, input int k,
                             input bit fast, input bit sub, input int exp_w,
                             input bit exp_ill, input string tag);
        int  n;
        bit  ill;
        @(negedge clk);
        addr = a; rd = !is_wr; wr = is_wr;
        cpu_div = 3'(k); adc_fast = fast; sub_clk = sub;
        #1;
        ill = illegal_o;
        n = 0;
        while (wait_o && n < 32) begin
            n++;
            @(negedge clk);
            #1;
        end
        check(n == exp_w, tag, n, exp_w);
        check(ill == exp_ill, {tag, " flag"}, int'(ill), int'(exp_ill));
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
    endtask

    localparam logic [7:0] ADDRS [10] =
        '{8'h10, 8'h20, 8'h28, 8'h40, 8'h41, 8'h42, 8'h43, 8'h44, 8'h00, 8'h45};

    initial begin
        // R1: access presented during reset
        @(negedge clk);
        addr = 8'h10; wr = 1'b1;
        #1;
        check(wait_o == 1'b0, "R1", int'(wait_o), 0);
        check(illegal_o == 1'b0, "R1", int'(illegal_o), 0);
        sub_clk = 1'b1;
        #0.5;
        check(illegal_o == 1'b0, "R1", int'(illegal_o), 0);
        @(negedge clk);
        wr = 1'b0; sub_clk = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Full sweep
        for (int ai = 0; ai < 10; ai++) begin
            for (int dir = 0; dir < 2; dir++) begin
                for (int f = 0; f < 2; f++) begin
                    for (int k = 0; k < 8; k++) begin
                        for (int s = 0; s < 2; s++) begin
                            int    w;
                            string tag;
                            logic [7:0] a;
                            a = ADDRS[ai];
                            w = -1;
                            tag = "R7";
                            if (a == 8'h10 && dir == 1) begin w = 3; tag = "R2"; end
                            else if ((a == 8'h20 || a == 8'h28) && dir == 0) begin w = 1; tag = "R3"; end
                            else if ((a >= 8'h40 && a <= 8'h43 && dir == 1) ||
                                     (a == 8'h44 && dir == 0)) begin
                                w = ref_adc(k, bit'(f));
                                tag = (k > 4) ? "R6" : ((w == 0) ? "R5" : "R4");
                            end
                            if (w < 0) begin
                                do_access(a, bit'(dir), k, bit'(f), bit'(s), 0, 1'b0, tag);
                            end else if (s == 1) begin
                                do_access(a, bit'(dir), k, bit'(f), 1'b1, 0, 1'b1, "R8");
                            end else begin
                                do_access(a, bit'(dir), k, bit'(f), 1'b0, w, 1'b0, tag);
                            end
                        end
                    end
                end
            end
        end

        // R9: strobe held across two watchdog writes: 1,1,1,0 then 1,1,1,0
        @(negedge clk);
        addr = 8'h10; wr = 1'b1; rd = 1'b0; sub_clk = 1'b0;
        for (int c = 0; c < 8; c++) begin
            #1;
            check(wait_o == ((c % 4) != 3), "R9", int'(wait_o), int'((c % 4) != 3));
            @(negedge clk);
        end
        wr = 1'b0;
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule